// File: doc/BRIEF.md
# Per-Rank Activate Window Limiter

This block tracks, for every rank of a memory channel, how many row activates were issued during the most recent stretch of memory cycles. When a rank has reached the permitted number of activates inside that window, a flag for that rank goes high. A command scheduler reads these flags and holds back further activates to a flagged rank. Choosing which command to issue is left to the scheduler.

Each issued activate arrives as a one-cycle strobe with the bank index it targets. The block derives the rank from the bank index. Each rank keeps a history register with one bit per memory cycle. The register shifts every cycle, and a new activate enters at its low end. The window length comes from a plain configuration input. A length above the history depth is clamped, and an error flag reports the clamp. The activate strobe is a control pulse rather than a data stream, so it has no ready signal and is never back-pressured. Every pulse with the valid bit set is recorded.

Top module: `act_window_limiter`

## Requirements
- R1: While reset is held and after it is released, all rank flags and the error flag are 0, and no activate from before reset is counted.
- R2: The rank of an activate is its bank index divided by BANKS_PER_RANK (8 by default: banks 0-7 are rank 0, banks 8-15 are rank 1, and so on). An activate changes the count of that rank only.
- R3: A rank flag is 1 in the cycle after a clock edge when the number of activates to that rank sampled at that edge and the L-1 edges before it is at least ACT_LIMIT (default 4). L is the effective window length. Otherwise the flag is 0.
- R4: An activate sampled at edge k is counted for exactly L cycles. It stops counting from edge k+L on, so a flag held up by that activate drops after edge k+L.
- R5: A configured length above MAX_WIN (62) is used as 62. The error flag is 1 in the cycle after an edge that samples such a length, and it returns to 0 after an edge that samples a legal length.
- R6: A configured length of 0 is used as 1, and it does not raise the error flag.
- R7: When the effective length changes, the count is rebuilt at once from the retained history of the last L edges. Shrinking the window drops older activates. Growing it back counts them again, as long as they fall within the new window.
- R8: With the activate valid input low, the bank index is ignored and no activate is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | An activate is issued this cycle |
| act_bank | input | BANK_W (5) | Bank index of the activate |
| win_cfg | input | CFG_W (7) | Requested window length in cycles |
| rank_full | output | NUM_RANKS (4) | Per-rank flag: activate limit reached in window |
| win_err | output | 1 | Requested window length was out of range and clamped |

## Verification
The hardest case to reach from the ports is a change of window length while the history still holds activates that are older than the new window but younger than the old one. Reaching it checks that the count is rebuilt rather than kept running. The stimulus places four activates five cycles apart under a 30-cycle window. It then shrinks the window to 8, which drops the older activates and lowers the flag. It then restores 30 before the activates age past it, so the flag must come back without any new activate. A separate run with a clamped 100-cycle window spaces activates 20 cycles apart, so the flag can only drop exactly 62 cycles after the first of them.

// File: rtl/actwin_pkg.sv
package actwin_pkg;

  localparam int HIST_MAX = 64;

  function automatic logic [6:0] ones64(input logic [HIST_MAX-1:0] v);
    logic [6:0] s;
    s = '0;
    for (int i = 0; i < HIST_MAX; i++) s = s + 7'(v[i]);
    return s;
  endfunction

  function automatic logic [HIST_MAX-1:0] low_mask(input logic [6:0] n);
    logic [HIST_MAX-1:0] m;
    for (int i = 0; i < HIST_MAX; i++) m[i] = (7'(i) < n);
    return m;
  endfunction

endpackage

// File: rtl/actwin_len_ctl.sv
module actwin_len_ctl #(
  parameter int MAX_WIN = 62,
  parameter int CFG_W   = 7,
  localparam int LEN_W  = $clog2(MAX_WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  output logic [LEN_W-1:0] eff_len,
  output logic [LEN_W-1:0] len_q,
  output logic             reload,
  output logic             err_q
);

  logic too_long;

  always_comb begin
    too_long = (cfg > CFG_W'(MAX_WIN));
    if (cfg == '0)    eff_len = LEN_W'(1);
    else if (too_long) eff_len = LEN_W'(MAX_WIN);
    else               eff_len = LEN_W'(cfg);
    reload = (eff_len != len_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= LEN_W'(MAX_WIN);
      err_q <= 1'b0;
    end else begin
      len_q <= eff_len;
      err_q <= too_long;
    end
  end

  // R5: the held length always stays inside the legal range
  a_r5_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q >= LEN_W'(1)) && (len_q <= LEN_W'(MAX_WIN)));

  // R5: an oversize request raises the error on the following cycle
  a_r5_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg > CFG_W'(MAX_WIN)) |=> err_q);

  // R6: a zero request becomes a one-cycle window without error
  a_r6_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == '0) |=> ((len_q == LEN_W'(1)) && !err_q));

endmodule

// File: rtl/actwin_rank_dec.sv
module actwin_rank_dec #(
  parameter int NUM_RANKS      = 4,
  parameter int BANKS_PER_RANK = 8,
  localparam int BANK_W = $clog2(NUM_RANKS * BANKS_PER_RANK)
) (
  input  logic              act_valid,
  input  logic [BANK_W-1:0] act_bank,
  output logic [NUM_RANKS-1:0] hit
);

  logic [BANK_W-1:0] rank_idx;

  assign rank_idx = act_bank / BANK_W'(BANKS_PER_RANK);

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_hit
    assign hit[r] = act_valid && (rank_idx == BANK_W'(r));
  end

endmodule

// File: rtl/actwin_rank_slot.sv
module actwin_rank_slot
  import actwin_pkg::*;
#(
  parameter int MAX_WIN   = 62,
  parameter int ACT_LIMIT = 4,
  localparam int LEN_W    = $clog2(MAX_WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [LEN_W-1:0] eff_len,
  input  logic [LEN_W-1:0] len_q,
  input  logic             reload,
  output logic             full
);

  logic [MAX_WIN-1:0]  hist, hist_n;
  logic [LEN_W-1:0]    cnt, cnt_n;
  logic                leave;
  logic [LEN_W:0]      run_sum;
  logic [6:0]          recount;

  always_comb begin
    hist_n  = {hist[MAX_WIN-2:0], hit};
    leave   = hist[len_q - LEN_W'(1)];
    run_sum = {1'b0, cnt} + (LEN_W+1)'(hit) - (LEN_W+1)'(leave);
    recount = ones64(HIST_MAX'(hist_n) & low_mask(7'(eff_len)));
    cnt_n   = reload ? LEN_W'(recount) : run_sum[LEN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
      cnt  <= '0;
    end else begin
      hist <= hist_n;
      cnt  <= cnt_n;
    end
  end

  assign full = (cnt >= LEN_W'(ACT_LIMIT));

  // R4: the running count equals the activates held inside the current window
  a_r4_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    7'(cnt) == ones64(HIST_MAX'(hist) & low_mask(7'(len_q))));

  // R3: the flag can only rise after an activate or a length change
  a_r3_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> ($past(hit) || $past(reload)));

  // R4: the flag can only fall on a cycle without an activate, or on a length change
  a_r4_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> (!$past(hit) || $past(reload)));

  // R8: a cycle without an activate leaves no mark in the history
  a_r8_no_ghost: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !hist[0]);

endmodule

// File: rtl/act_window_limiter.sv
module act_window_limiter #(
  parameter int NUM_RANKS      = 4,
  parameter int BANKS_PER_RANK = 8,
  parameter int MAX_WIN        = 62,
  parameter int ACT_LIMIT      = 4,
  parameter int CFG_W          = 7,
  localparam int BANK_W = $clog2(NUM_RANKS * BANKS_PER_RANK),
  localparam int LEN_W  = $clog2(MAX_WIN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 act_valid,
  input  logic [BANK_W-1:0]    act_bank,
  input  logic [CFG_W-1:0]     win_cfg,
  output logic [NUM_RANKS-1:0] rank_full,
  output logic                 win_err
);

  initial begin
    a_r5_depth_fits: assert (MAX_WIN >= 2 && MAX_WIN <= 62);
  end

  logic [LEN_W-1:0]     eff_len, len_q;
  logic                 reload;
  logic [NUM_RANKS-1:0] hit;

  actwin_len_ctl #(.MAX_WIN(MAX_WIN), .CFG_W(CFG_W)) u_len (
    .clk(clk), .rst_n(rst_n), .cfg(win_cfg),
    .eff_len(eff_len), .len_q(len_q), .reload(reload), .err_q(win_err)
  );

  actwin_rank_dec #(.NUM_RANKS(NUM_RANKS), .BANKS_PER_RANK(BANKS_PER_RANK)) u_dec (
    .act_valid(act_valid), .act_bank(act_bank), .hit(hit)
  );

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    actwin_rank_slot #(.MAX_WIN(MAX_WIN), .ACT_LIMIT(ACT_LIMIT)) u_slot (
      .clk(clk), .rst_n(rst_n), .hit(hit[r]),
      .eff_len(eff_len), .len_q(len_q), .reload(reload),
      .full(rank_full[r])
    );
  end

  // R2: at most one rank is charged per activate
  a_r2_single_rank: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> $countones(hit) == 1);

  // R1: directly after reset no rank is flagged
  a_r1_clear_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (rank_full == '0) && !win_err);

endmodule

// File: tb/act_window_limiter_test.sv
module act_window_limiter_test;

  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       act_valid = 1'b0;
  logic [4:0] act_bank = '0;
  logic [6:0] win_cfg = 7'd10;
  logic [3:0] rank_full;
  logic       win_err;

  act_window_limiter uut (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_bank(act_bank),
    .win_cfg(win_cfg), .rank_full(rank_full), .win_err(win_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int edge_n = 0;
  bit finished = 0;
  string cur_tag = "R1";
  int acts [NR][$];
  logic [4:0] exp_q [$];
  string tag_q [$];

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected outcome
  task automatic step(input bit v, input int bank, input int cfg);
    int len, cnt;
    logic [4:0] e;
    @(negedge clk);
    act_valid = v;
    act_bank  = 5'(bank);
    win_cfg   = 7'(cfg);
    @(posedge clk);
    #1;
    edge_n++;
    if (v) acts[bank / 8].push_back(edge_n);
    len = (cfg == 0) ? 1 : ((cfg > 62) ? 62 : cfg);
    for (int r = 0; r < NR; r++) begin
      cnt = 0;
      foreach (acts[r][i]) if (edge_n - acts[r][i] < len) cnt++;
      e[r] = (cnt >= 4);
    end
    e[4] = (cfg > 62);
    exp_q.push_back(e);
    tag_q.push_back(cur_tag);
  endtask

  task automatic idle(input int n, input int cfg);
    for (int i = 0; i < n; i++) step(1'b0, 0, cfg);
  endtask

  // monitor: compares design outputs against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [4:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({win_err, rank_full} !== e) begin
        errors++;
        $display("FAIL %s cycle %0d: err=%b flags=%b expected err=%b flags=%b",
                 t, edge_n, win_err, rank_full, e[4], e[3:0]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state, with activates driven while reset is held
    act_valid = 1'b1;
    act_bank  = 5'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rank_full !== 4'b0 || win_err !== 1'b0) begin
      errors++;
      $display("FAIL R1: flags=%b err=%b expected 0000 0", rank_full, win_err);
    end
    act_valid = 1'b0;
    rst_n = 1'b1;
    cur_tag = "R1";
    idle(2, 10);

    // R3: four activates inside a 10-cycle window flag rank 0
    cur_tag = "R3";
    step(1, 0, 10); step(1, 3, 10); step(1, 5, 10); step(1, 7, 10);
    // R4: flag drops exactly when the oldest activate ages out
    cur_tag = "R4";
    idle(12, 10);

    // R2: banks 8-15 go to rank 1, bank 31 to rank 3
    cur_tag = "R2";
    step(1, 8, 10); step(1, 15, 10); step(1, 31, 10); step(1, 12, 10); step(1, 9, 10);
    idle(12, 10);

    // R8: bank index with valid low records nothing
    cur_tag = "R8";
    for (int i = 0; i < 6; i++) step(0, 16, 10);

    // R3: spaced activates never fill a 6-cycle window; back-to-back ones do
    cur_tag = "R3";
    for (int i = 0; i < 5; i++) begin step(1, 16, 6); step(0, 0, 6); end
    step(1, 17, 6); step(1, 18, 6); step(1, 19, 6); step(1, 20, 6);
    idle(8, 6);

    // R5: oversize length clamps to 62 and raises the error
    cur_tag = "R5";
    for (int k = 0; k < 4; k++) begin
      step(1, 24, 100);
      idle(19, 100);
    end
    idle(6, 100);
    idle(3, 20);

    // R6: zero length behaves as a single-cycle window
    cur_tag = "R6";
    step(1, 0, 0); step(1, 1, 0); step(1, 2, 0); step(1, 3, 0);
    idle(3, 0);
    idle(64, 30);

    // R7: shrinking then regrowing the window recounts retained history
    cur_tag = "R7";
    for (int k = 0; k < 4; k++) begin
      step(1, 10, 30);
      idle(4, 30);
    end
    idle(2, 8);
    idle(2, 30);
    idle(30, 30);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule